// File: doc/BRIEF.md
# Stalling Display-Write Queue

This block sits between a CPU bus slave port and the memory controller of a video chip. Every CPU write to the video data port is placed in a short queue together with the target memory and the current auto-incrementing address. A drain side pulls entries out in arrival order and hands them to the memory controller, one access per access-slot pulse. Slots are scarce during active display and plentiful during blanking, so the queue absorbs short bursts of CPU writes without slowing the CPU.

When every queue slot is taken, the block holds back the bus acknowledge, and the CPU bus cycle stretches until an entry leaves. Three target memories are served: pattern memory, colour memory and vertical-scroll memory. Pattern memory is byte-wide, so one queued word costs two access slots there, while the other two memories take the word in a single access. The target, start address and per-write address step are loaded through a configuration strobe.

Top module: `disp_wr_queue`

## Requirements
- R1: After reset the queue is empty, no memory access is issued, no acknowledge is given, the address register is 0, the step is 2 and the target is colour memory (code 1).
- R2: A CPU write request (`cpu_wr_req` high) is acknowledged combinationally in the same clock when the queue is not full, and the write is stored at that clock edge.
- R3: While the queue holds DEPTH (4) entries and no entry completes its drain in that clock, `cpu_ack` stays low and the request stays pending.
- R4: A write pending against a full queue is acknowledged in the very clock in which the head entry completes its last memory access, and the queue stays full afterwards.
- R5: A pattern-memory entry (target code 0) is drained as two byte accesses (`mem_byte` high) in two separate slots: first the upper data byte at the entry address with bit 0 cleared, then the lower data byte at that address with bit 0 set, each byte on `mem_data[7:0]` with the upper half zero; the entry leaves the queue only after the second.
- R6: A colour-memory (code 1) or vertical-scroll (code 2) entry is drained as one word access (`mem_byte` low) carrying the full data word at the stored entry address.
- R7: Memory accesses occur strictly in the order the writes were acknowledged.
- R8: Each acknowledged write stores the current address and target, then the address advances by the configured step, modulo 2^16.
- R9: `mem_wr` is high only in a clock where `slot_tick` is high and the queue is not empty; with no slots nothing drains.
- R10: `q_empty` is high exactly when no entry is queued and `q_full` exactly when DEPTH entries are queued.
- R11: When `cfg_load` and an acknowledged write share a clock, the write uses the old address and target, and the loaded address, step and target take effect for the following writes without the step being added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load target, address and step |
| cfg_tgt | input | 2 | Target code: 0 pattern, 1 colour, 2 vertical scroll |
| cfg_addr | input | 16 | Start address to load |
| cfg_step | input | 8 | Address step added per accepted write |
| cpu_wr_req | input | 1 | CPU data write request, held until acknowledged |
| cpu_wr_data | input | 16 | CPU write data |
| cpu_ack | output | 1 | Bus acknowledge for the write |
| slot_tick | input | 1 | Memory controller can take one access this clock |
| mem_wr | output | 1 | Memory access issued this clock |
| mem_tgt | output | 2 | Target of the access |
| mem_byte | output | 1 | Access is a single byte on mem_data[7:0] |
| mem_addr | output | 16 | Access address |
| mem_data | output | 16 | Access data |
| q_empty | output | 1 | Queue holds no entry |
| q_full | output | 1 | Queue holds DEPTH entries |

## Verification
The bench fills the queue with slots switched off to see the acknowledge withheld, then releases single slot pulses so that a word-target head and a pattern-target head can be told apart: the first frees the stall after one pulse, the second only after two. A sweep over all three targets and several address steps, including zero, odd and wrapping steps, with slots every third clock, compares the full access log against addresses and byte splits computed arithmetically, which separates ordering faults from address-step faults. A write coinciding with a configuration load and a long stretch without slots isolate the load precedence and the slot gating.

// File: rtl/dwq_pkg.sv
package dwq_pkg;
  typedef enum logic [1:0] {
    TGT_PAT = 2'd0,
    TGT_COL = 2'd1,
    TGT_VSC = 2'd2,
    TGT_RSV = 2'd3
  } tgt_e;

  // Only the byte-wide target needs two accesses per queued word.
  function automatic logic is_byte_tgt(input logic [1:0] t);
    return t == TGT_PAT;
  endfunction
endpackage

// File: rtl/dwq_addr.sv
module dwq_addr #(
  parameter int AW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [1:0]    cfg_tgt,
  input  logic [AW-1:0] cfg_addr,
  input  logic [SW-1:0] cfg_step,
  input  logic          accept,
  output logic [AW-1:0] cur_addr,
  output logic [1:0]    cur_tgt
);
  import dwq_pkg::*;

  logic [AW-1:0] addr_q, addr_d;
  logic [SW-1:0] step_q, step_d;
  logic [1:0]    tgt_q, tgt_d;
  logic          en;

  always_comb begin
    addr_d = addr_q;
    step_d = step_q;
    tgt_d  = tgt_q;
    if (cfg_load) begin
      addr_d = cfg_addr;
      step_d = cfg_step;
      tgt_d  = cfg_tgt;
    end else if (accept) begin
      addr_d = addr_q + AW'(step_q);
    end
  end

  assign en = cfg_load | accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      step_q <= SW'(2);
      tgt_q  <= TGT_COL;
    end else if (en) begin
      addr_q <= addr_d;
      step_q <= step_d;
      tgt_q  <= tgt_d;
    end
  end

  assign cur_addr = addr_q;
  assign cur_tgt  = tgt_q;
endmodule

// File: rtl/dwq_ring.sv
module dwq_ring #(
  parameter int DEPTH = 4,
  parameter int EW    = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [EW-1:0] wdata,
  output logic [EW-1:0] rdata,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) wptr_d = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop)  rptr_d = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (push | pop) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wen;
    assign wen = push && (wptr_q == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q[i] <= '0;
      else if (wen) slot_q[i] <= wdata;
    end
  end

  assign rdata = slot_q[rptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/dwq_drain.sv
module dwq_drain #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_tick,
  input  logic          head_valid,
  input  logic [1:0]    head_tgt,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          pop,
  output logic          mem_wr,
  output logic [1:0]    mem_tgt,
  output logic          mem_byte,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);
  import dwq_pkg::*;
  localparam int BW = DW / 2;

  logic phase_q, phase_d;
  logic issue, head_byte, last_acc, phase_en;

  assign head_byte = is_byte_tgt(head_tgt);
  assign issue     = slot_tick && head_valid;
  assign last_acc  = !head_byte || phase_q;
  assign pop       = issue && last_acc;
  assign phase_en  = issue && head_byte;

  always_comb begin
    phase_d = phase_q;
    if (phase_en) phase_d = !phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= 1'b0;
    else if (phase_en) phase_q <= phase_d;
  end

  always_comb begin
    mem_wr   = issue;
    mem_tgt  = head_tgt;
    mem_byte = head_byte;
    if (head_byte) begin
      mem_addr = {head_addr[AW-1:1], phase_q};
      mem_data = {{BW{1'b0}}, phase_q ? head_data[BW-1:0] : head_data[DW-1:BW]};
    end else begin
      mem_addr = head_addr;
      mem_data = head_data;
    end
  end
endmodule

// File: rtl/disp_wr_queue.sv
module disp_wr_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int SW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [1:0]    cfg_tgt,
  input  logic [AW-1:0] cfg_addr,
  input  logic [SW-1:0] cfg_step,
  input  logic          cpu_wr_req,
  input  logic [DW-1:0] cpu_wr_data,
  output logic          cpu_ack,
  input  logic          slot_tick,
  output logic          mem_wr,
  output logic [1:0]    mem_tgt,
  output logic          mem_byte,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          q_empty,
  output logic          q_full
);
  localparam int EW = DW + 2 + AW;

  logic [1:0]    rst_sync_q;
  logic          srst_n;
  logic          accept, pop;
  logic [AW-1:0] cur_addr;
  logic [1:0]    cur_tgt;
  logic [EW-1:0] wr_ent, rd_ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  // A drain that completes this clock frees a slot for the write now.
  assign accept  = cpu_wr_req && srst_n && (!q_full || pop);
  assign cpu_ack = accept;
  assign wr_ent  = {cpu_wr_data, cur_tgt, cur_addr};

  dwq_addr #(.AW(AW), .SW(SW)) u_addr (
    .clk(clk), .rst_n(srst_n),
    .cfg_load(cfg_load), .cfg_tgt(cfg_tgt), .cfg_addr(cfg_addr), .cfg_step(cfg_step),
    .accept(accept), .cur_addr(cur_addr), .cur_tgt(cur_tgt)
  );

  dwq_ring #(.DEPTH(DEPTH), .EW(EW)) u_ring (
    .clk(clk), .rst_n(srst_n),
    .push(accept), .pop(pop), .wdata(wr_ent), .rdata(rd_ent),
    .empty(q_empty), .full(q_full)
  );

  dwq_drain #(.AW(AW), .DW(DW)) u_drain (
    .clk(clk), .rst_n(srst_n),
    .slot_tick(slot_tick), .head_valid(!q_empty),
    .head_tgt(rd_ent[AW +: 2]), .head_addr(rd_ent[AW-1:0]), .head_data(rd_ent[EW-1 -: DW]),
    .pop(pop), .mem_wr(mem_wr), .mem_tgt(mem_tgt), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );
endmodule

// File: rtl/dwq_chk.sv
module dwq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          srst_n,
  input logic          cpu_wr_req,
  input logic          cpu_ack,
  input logic          slot_tick,
  input logic          mem_wr,
  input logic          mem_byte,
  input logic [AW-1:0] mem_addr,
  input logic          q_empty,
  input logic          q_full
);
  // R2
  ack_free_chk: assert property (@(posedge clk) disable iff (!srst_n)
    cpu_wr_req && !q_full |-> cpu_ack);

  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!srst_n)
    q_full && !slot_tick |-> !cpu_ack);

  // R9
  slot_gate_chk: assert property (@(posedge clk) disable iff (!srst_n)
    mem_wr |-> slot_tick && !q_empty);

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(q_empty && q_full));

  // R10
  fill_chk: assert property (@(posedge clk) disable iff (!srst_n)
    cpu_ack && !mem_wr |=> !q_empty);

  // R5
  byte_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    mem_wr && mem_byte && !mem_addr[0] |=> !q_empty);
endmodule

bind disp_wr_queue dwq_chk #(.AW(AW)) u_chk (
  .clk(clk), .srst_n(srst_n), .cpu_wr_req(cpu_wr_req), .cpu_ack(cpu_ack),
  .slot_tick(slot_tick), .mem_wr(mem_wr), .mem_byte(mem_byte), .mem_addr(mem_addr),
  .q_empty(q_empty), .q_full(q_full)
);

// File: tb/disp_wr_queue_tb.sv
`timescale 1ns/1ps
module disp_wr_queue_tb;
  logic        clk, rst_n;
  logic        cfg_load;
  logic [1:0]  cfg_tgt;
  logic [15:0] cfg_addr;
  logic [7:0]  cfg_step;
  logic        cpu_wr_req;
  logic [15:0] cpu_wr_data;
  logic        cpu_ack;
  logic        slot_tick;
  logic        mem_wr, mem_byte;
  logic [1:0]  mem_tgt;
  logic [15:0] mem_addr, mem_data;
  logic        q_empty, q_full;

  disp_wr_queue u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_tgt(cfg_tgt),
    .cfg_addr(cfg_addr), .cfg_step(cfg_step), .cpu_wr_req(cpu_wr_req),
    .cpu_wr_data(cpu_wr_data), .cpu_ack(cpu_ack), .slot_tick(slot_tick),
    .mem_wr(mem_wr), .mem_tgt(mem_tgt), .mem_byte(mem_byte), .mem_addr(mem_addr),
    .mem_data(mem_data), .q_empty(q_empty), .q_full(q_full)
  );

  int total = 0, bad = 0;
  int slot_mode = 0;
  logic manual = 1'b0;
  int cyc = 0;

  logic [34:0] exp_q [512];
  logic [34:0] log_q [512];
  int exp_n = 0, log_n = 0;

  logic [15:0] m_addr;
  logic [7:0]  m_step;
  logic [1:0]  m_tgt;

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // slot generator: 0 manual pulses only, 1 every clock, 2 every third clock
  initial begin
    slot_tick = 1'b0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      case (slot_mode)
        1:       slot_tick = 1'b1;
        2:       slot_tick = (cyc % 3 == 0) || manual;
        default: slot_tick = manual;
      endcase
      manual = 1'b0;
    end
  end

  // access log and slot gating check
  always @(negedge clk) begin
    if (mem_wr) begin
      log_q[log_n] = {mem_tgt, mem_byte, mem_addr, mem_data};
      log_n++;
      total++;
      if (!slot_tick) begin
        bad++;
        $display("FAIL R9 access without slot actual=%0d expected=%0d", slot_tick, 1);
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk); #0.5;
  endtask

  task automatic push_exp(input logic [15:0] d);
    if (m_tgt == 2'd0) begin
      exp_q[exp_n] = {2'd0, 1'b1, m_addr[15:1], 1'b0, 8'h00, d[15:8]}; exp_n++;
      exp_q[exp_n] = {2'd0, 1'b1, m_addr[15:1], 1'b1, 8'h00, d[7:0]};  exp_n++;
    end else begin
      exp_q[exp_n] = {m_tgt, 1'b0, m_addr, d}; exp_n++;
    end
    m_addr = m_addr + 16'(m_step);
  endtask

  task automatic cfg(input logic [1:0] t, input logic [15:0] a, input logic [7:0] s);
    cfg_load = 1'b1; cfg_tgt = t; cfg_addr = a; cfg_step = s;
    tick();
    cfg_load = 1'b0;
    m_tgt = t; m_addr = a; m_step = s;
  endtask

  task automatic cpu_write(input logic [15:0] d, output int waited);
    waited = 0;
    cpu_wr_req = 1'b1; cpu_wr_data = d;
    forever begin
      @(negedge clk);
      if (cpu_ack) break;
      waited++;
      if (waited > 2000) break;
    end
    push_exp(d);
    tick();
    cpu_wr_req = 1'b0;
  endtask

  task automatic pulse_slot();
    manual = 1'b1;
    tick();
  endtask

  task automatic wait_drain(input string req);
    int n = 0;
    @(negedge clk);
    while (!q_empty && n < 5000) begin @(negedge clk); n++; end
    tick(); tick();
    chk(req, q_empty, 1);
  endtask

  task automatic check_log(input string req);
    chk(req, log_n, exp_n);
    for (int i = 0; i < exp_n; i++) begin
      if (i < log_n) chk(req, log_q[i], exp_q[i]);
    end
    exp_n = 0; log_n = 0;
  endtask

  initial begin
    #600000;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    logic [7:0] steps [6];
    rst_n = 1'b0; cfg_load = 1'b0; cfg_tgt = '0; cfg_addr = '0; cfg_step = '0;
    cpu_wr_req = 1'b0; cpu_wr_data = '0;
    m_addr = 16'h0000; m_step = 8'd2; m_tgt = 2'd1;
    steps[0] = 8'd0; steps[1] = 8'd1; steps[2] = 8'd2;
    steps[3] = 8'd5; steps[4] = 8'd128; steps[5] = 8'd255;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 / R10 reset state
    @(negedge clk);
    chk("R1 empty", q_empty, 1);
    chk("R10 full", q_full, 0);
    chk("R1 mem_wr", mem_wr, 0);
    chk("R1 ack", cpu_ack, 0);
    tick();

    // R1 reset address/target, R2 immediate ack, R10 full flag
    slot_mode = 0;
    cpu_write(16'hA1B2, w);
    chk("R2 no wait", w, 0);
    @(negedge clk); chk("R10 not empty", q_empty, 0);
    tick();
    cfg(2'd1, 16'h0040, 8'd2);
    for (int i = 0; i < 3; i++) begin
      cpu_write(16'h1000 + 16'(i), w);
      chk("R2 no wait", w, 0);
    end
    @(negedge clk); chk("R10 full", q_full, 1);
    tick();

    // R3 stall, R4 same-clock accept
    cpu_wr_req = 1'b1; cpu_wr_data = 16'h5555;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); chk("R3 ack held", cpu_ack, 0);
    end
    tick();
    manual = 1'b1;
    @(negedge clk);
    chk("R4 ack on drain", cpu_ack, 1);
    chk("R6 word drain", mem_wr, 1);
    push_exp(16'h5555);
    tick();
    cpu_wr_req = 1'b0;
    @(negedge clk); chk("R4 still full", q_full, 1);
    tick();
    slot_mode = 1;
    wait_drain("R7 drain");
    check_log("R6 R7 R1 log");

    // R5 pattern entry two accesses
    slot_mode = 0;
    cfg(2'd0, 16'h0101, 8'd1);
    cpu_write(16'hC3D4, w);
    pulse_slot();
    @(negedge clk);
    chk("R5 kept after first byte", q_empty, 0);
    chk("R5 one access", log_n, 1);
    tick();
    pulse_slot();
    @(negedge clk);
    chk("R5 gone after second byte", q_empty, 1);
    tick();
    check_log("R5 byte split");

    // R3 / R4 / R5 full queue with pattern head
    cfg(2'd0, 16'h0200, 8'd2);
    for (int i = 0; i < 4; i++) cpu_write(16'hAB00 + 16'(i), w);
    cpu_wr_req = 1'b1; cpu_wr_data = 16'h6A6B;
    manual = 1'b1;
    @(negedge clk); chk("R3 pattern first half", cpu_ack, 0);
    tick();
    manual = 1'b1;
    @(negedge clk); chk("R4 pattern second half", cpu_ack, 1);
    push_exp(16'h6A6B);
    tick();
    cpu_wr_req = 1'b0;
    slot_mode = 1;
    wait_drain("R5 drain");
    check_log("R5 R7 full pattern");

    // R8 / R7 sweep over targets and steps
    for (int t = 0; t < 3; t++) begin
      for (int s = 0; s < 6; s++) begin
        slot_mode = 2;
        cfg(2'(t), 16'hFFF0 + 16'(s * 3), steps[s]);
        for (int i = 0; i < 6; i++)
          cpu_write(16'((t * 4099) ^ (s * 257) ^ (i * 8191) ^ 16'h3C5A), w);
        wait_drain("R8 drain");
        check_log("R8 R7 sweep");
      end
    end

    // R11 config load with same-clock write
    slot_mode = 0;
    cfg(2'd1, 16'h0010, 8'd4);
    cpu_wr_req = 1'b1; cpu_wr_data = 16'h7777;
    cfg_load = 1'b1; cfg_tgt = 2'd2; cfg_addr = 16'h0300; cfg_step = 8'd1;
    @(negedge clk); chk("R11 ack", cpu_ack, 1);
    push_exp(16'h7777);
    tick();
    cpu_wr_req = 1'b0; cfg_load = 1'b0;
    m_tgt = 2'd2; m_addr = 16'h0300; m_step = 8'd1;
    cpu_write(16'h8888, w);
    cpu_write(16'h9999, w);

    // R9 nothing drains without slots
    repeat (10) tick();
    @(negedge clk);
    chk("R9 no access", log_n, 0);
    chk("R9 still queued", q_empty, 0);
    tick();
    slot_mode = 1;
    wait_drain("R11 drain");
    check_log("R11 log");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule